// File: doc/BRIEF.md
# Large-Page NAND Page Read Sequencer

This block runs a complete page read on an asynchronous 8-bit NAND device whose pages hold 2048 data bytes and 64 spare bytes, with 64 pages in a block. A host hands it a page index, a byte position in the page and a byte count through a valid/ready request. The block then drives the device pins itself. It issues the read opcode, the five address bytes and the confirm opcode. After a guard interval it waits for the ready/busy line to report that the page register is loaded. It then pulses the read strobe once per byte and passes each byte to a valid/ready output stream. Chip select is released when the transfer ends.

A spare-area request carries an offset into the 64 spare bytes. The block turns it into an ordinary read whose column is 2048 plus that offset. A request whose position lies outside the page, or whose count is zero, is refused before any pin moves. A device that stays busy longer than a limit supplied with the request is abandoned with an error.

Top module: `nand_pgrd_seq`

## Requirements
- R1: An accepted request produces, with chip select low, opcode 0x00 with CLE high, then exactly five address bytes with ALE high, then opcode 0x30 with CLE high. Each byte is taken by the device on the rising edge of WE#, and CLE and ALE are never high together.
- R2: Address byte 1 is column bits [7:0]. Address byte 2 carries column bits [11:8] in bits [3:0] and zeros in bits [7:4].
- R3: Address bytes 3, 4 and 5 are page-index bits [7:0], [15:8] and [23:16]. For example, page index 0x06D640 with column 0x4B8 gives the bytes 0xB8, 0x04, 0x40, 0xD6, 0x06.
- R4: With `req_spare` = 1, `req_col` is a spare offset and the column sent is 2048 + offset, so column bit 11 is set. With `req_spare` = 0 the column is sent as given.
- R5: RE# does not fall within TWB_CYC clocks of the WE# rising edge that carries 0x30, even when R/B# never goes low.
- R6: While R/B# is low, RE# stays high. The first RE# low pulse comes only after R/B# has been seen high.
- R7: Each RE# low pulse yields one byte, taken from `nand_io_in` at the clock edge on which RE# rises. The byte is shown on `out_data` with `out_valid` and is held until `out_ready`. No further RE# pulse starts while a byte waits.
- R8: The number of bytes delivered is the smaller of `req_len` and 2112 minus the column. `out_last` marks the final byte. Chip select then rises and `done` pulses for one clock.
- R9: If R/B# is still low `busy_limit` clocks after the guard interval, `err_timeout` pulses for one clock, chip select rises, and no byte is read.
- R10: A request with column above 2111 (normal mode), spare offset above 63 (spare mode), or `req_len` = 0 makes `err_range` pulse in the clock after acceptance. Chip select stays high and no opcode is sent.
- R11: During reset, chip select, WE# and RE# are high, CLE and ALE are low, `out_valid` is low and `req_ready` is high.
- R12: `req_ready` is high only while the block is idle, so it is low for as long as chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_row | input | 24 | Page index (block × 64 + page in block) |
| req_col | input | 12 | Byte position in the page, or spare offset in spare mode |
| req_spare | input | 1 | 1: `req_col` is an offset into the spare area |
| req_len | input | LEN_W | Number of bytes requested |
| busy_limit | input | TMR_W | Clocks allowed for R/B# to rise after the guard interval |
| nand_ce_n | output | 1 | Chip select, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_oe | output | 1 | Drive enable for the I/O bus |
| nand_io_out | output | 8 | Opcode or address byte driven to the device |
| nand_io_in | input | 8 | Data byte from the device |
| nand_rb_n | input | 1 | Device ready (1) / busy (0) |
| out_valid | output | 1 | Read byte available |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Read byte |
| out_last | output | 1 | Current byte is the final one |
| done | output | 1 | One-clock pulse when a read completes |
| err_range | output | 1 | One-clock pulse for a refused request |
| err_timeout | output | 1 | One-clock pulse for a busy timeout |

## Verification
The bench builds the block with PULSE_CYC = 2, TWB_CYC = 6, TMR_W = 10 and LEN_W = 12. These values keep each bus cycle short, make the guard gap after the confirm opcode measurable in clocks, and allow the busy timeout to expire after a few tens of cycles. With LEN_W = 12, counts above the room left in the page can be requested, so clipping at column 2111 is exercised in both the data area and the spare area.

// File: rtl/nand_pgrd_pkg.sv
package nand_pgrd_pkg;

    // Page geometry of the supported device family
    localparam int unsigned COL_W       = 12;
    localparam int unsigned ROW_W       = 24;
    localparam int unsigned DATA_BYTES  = 2048;
    localparam int unsigned SPARE_BYTES = 64;
    localparam int unsigned PAGE_BYTES  = DATA_BYTES + SPARE_BYTES;
    localparam int unsigned ADDR_CYCLES = 5;
    localparam int unsigned COL_CYCLES  = 2;
    localparam int unsigned ROW_CYCLES  = ADDR_CYCLES - COL_CYCLES;

    localparam logic [7:0] OP_READ    = 8'h00;
    localparam logic [7:0] OP_CONFIRM = 8'h30;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD1,
        ST_ADDR,
        ST_CMD2,
        ST_TWB,
        ST_WAITRB,
        ST_RDLO,
        ST_OUT,
        ST_FIN,
        ST_TOUT
    } seq_state_e;

endpackage

// File: rtl/nand_pgrd_map.sv
// Turns a host request into the effective column and the clipped byte count,
// and judges whether the request can be served at all.
module nand_pgrd_map
    import nand_pgrd_pkg::*;
#(
    parameter int unsigned LEN_W = 12
) (
    input  logic [COL_W-1:0] col_in,
    input  logic             spare_in,
    input  logic [LEN_W-1:0] len_in,
    output logic [COL_W-1:0] col_eff,
    output logic [LEN_W-1:0] count,
    output logic             ok
);
    localparam int unsigned CW = ((COL_W > LEN_W) ? COL_W : LEN_W) + 1;

    logic [CW-1:0] col_sum;
    logic [CW-1:0] room;
    logic [CW-1:0] len_ext;

    always_comb begin
        col_sum = spare_in ? (CW'(col_in) + CW'(DATA_BYTES)) : CW'(col_in);
        ok      = (len_in != '0) &&
                  (spare_in ? (CW'(col_in) < CW'(SPARE_BYTES))
                            : (CW'(col_in) < CW'(PAGE_BYTES)));
        col_eff = col_sum[COL_W-1:0];
        room    = CW'(PAGE_BYTES) - col_sum;
        len_ext = CW'(len_in);
        count   = (len_ext < room) ? len_in : room[LEN_W-1:0];
    end

endmodule

// File: rtl/nand_pgrd_tmr.sv
// Shared down-counter: loaded with N-1 it reports zero N clocks after the load.
module nand_pgrd_tmr #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/nand_pgrd_seq.sv
module nand_pgrd_seq
    import nand_pgrd_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 2,   // clocks per strobe phase
    parameter int unsigned TWB_CYC   = 10,  // guard after the confirm opcode
    parameter int unsigned TMR_W     = 16,
    parameter int unsigned LEN_W     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [23:0]      req_row,
    input  logic [11:0]      req_col,
    input  logic             req_spare,
    input  logic [LEN_W-1:0] req_len,
    input  logic [TMR_W-1:0] busy_limit,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic             nand_io_oe,
    output logic [7:0]       nand_io_out,
    input  logic [7:0]       nand_io_in,
    input  logic             nand_rb_n,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic             done,
    output logic             err_range,
    output logic             err_timeout
);
    localparam int unsigned IDX_W    = $clog2(ADDR_CYCLES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_CYCLES - 1);
    localparam logic [TMR_W-1:0] PULSE_LD = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0] TWB_LD   = TMR_W'(TWB_CYC - 1);

    typedef struct packed {
        seq_state_e       st;
        logic             ph;      // 0: strobe low phase, 1: strobe high phase
        logic [IDX_W-1:0] idx;     // address byte index
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic [LEN_W-1:0] rem;     // bytes still to deliver
        logic [7:0]       data;
        logic [1:0]       rb;      // ready/busy synchronizer
        logic             err_rng;
    } regs_t;

    regs_t r_d, r_q;

    logic [COL_W-1:0] map_col;
    logic [LEN_W-1:0] map_cnt;
    logic             map_ok;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;
    logic [7:0]       abyte [ADDR_CYCLES];

    nand_pgrd_map #(.LEN_W(LEN_W)) u_map (
        .col_in   (req_col),
        .spare_in (req_spare),
        .len_in   (req_len),
        .col_eff  (map_col),
        .count    (map_cnt),
        .ok       (map_ok)
    );

    nand_pgrd_tmr #(.W(TMR_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .val   (tmr_val),
        .zero  (tmr_zero)
    );

    // Address byte layout: two column cycles then the page index bytes
    assign abyte[0] = r_q.col[7:0];
    assign abyte[1] = {4'b0000, r_q.col[COL_W-1:8]};
    for (genvar g = 0; g < ROW_CYCLES; g++) begin : g_row
        assign abyte[COL_CYCLES + g] = r_q.row[8*g +: 8];
    end

    always_comb begin
        r_d         = r_q;
        r_d.rb      = {r_q.rb[0], nand_rb_n};
        r_d.err_rng = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = PULSE_LD;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (map_ok) begin
                        r_d.st   = ST_CMD1;
                        r_d.ph   = 1'b0;
                        r_d.col  = map_col;
                        r_d.row  = req_row;
                        r_d.rem  = map_cnt;
                        tmr_load = 1'b1;
                    end else begin
                        r_d.err_rng = 1'b1;
                    end
                end
            end
            ST_CMD1, ST_ADDR, ST_CMD2: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (!r_q.ph) begin
                        r_d.ph = 1'b1;
                    end else begin
                        r_d.ph = 1'b0;
                        case (r_q.st)
                            ST_CMD1: begin
                                r_d.st  = ST_ADDR;
                                r_d.idx = '0;
                            end
                            ST_ADDR: begin
                                if (r_q.idx == LAST_IDX) r_d.st = ST_CMD2;
                                else                     r_d.idx = r_q.idx + 1'b1;
                            end
                            default: begin
                                r_d.st  = ST_TWB;
                                tmr_val = TWB_LD;
                            end
                        endcase
                    end
                end
            end
            ST_TWB: begin
                if (tmr_zero) begin
                    r_d.st   = ST_WAITRB;
                    tmr_load = 1'b1;
                    tmr_val  = busy_limit;
                end
            end
            ST_WAITRB: begin
                if (r_q.rb[1]) begin
                    r_d.st   = ST_RDLO;
                    tmr_load = 1'b1;
                end else if (tmr_zero) begin
                    r_d.st = ST_TOUT;
                end
            end
            ST_RDLO: begin
                if (tmr_zero) begin
                    r_d.data = nand_io_in;
                    r_d.st   = ST_OUT;
                end
            end
            ST_OUT: begin
                if (out_ready) begin
                    r_d.rem = r_q.rem - 1'b1;
                    if (r_q.rem == LEN_W'(1)) begin
                        r_d.st = ST_FIN;
                    end else begin
                        r_d.st   = ST_RDLO;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_FIN, ST_TOUT: r_d.st = ST_IDLE;
            default:         r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
            r_q.rb      <= 2'b11;
        end else begin
            r_q <= r_d;
        end
    end

    logic wr_phase;
    assign wr_phase    = (r_q.st == ST_CMD1) || (r_q.st == ST_ADDR) || (r_q.st == ST_CMD2);

    assign req_ready   = (r_q.st == ST_IDLE);
    assign nand_ce_n   = (r_q.st == ST_IDLE) || (r_q.st == ST_FIN) || (r_q.st == ST_TOUT);
    assign nand_cle    = (r_q.st == ST_CMD1) || (r_q.st == ST_CMD2);
    assign nand_ale    = (r_q.st == ST_ADDR);
    assign nand_we_n   = !(wr_phase && !r_q.ph);
    assign nand_io_oe  = wr_phase;
    assign nand_io_out = (r_q.st == ST_CMD1) ? OP_READ :
                         (r_q.st == ST_CMD2) ? OP_CONFIRM : abyte[r_q.idx];
    assign nand_re_n   = (r_q.st != ST_RDLO);
    assign out_valid   = (r_q.st == ST_OUT);
    assign out_data    = r_q.data;
    assign out_last    = (r_q.st == ST_OUT) && (r_q.rem == LEN_W'(1));
    assign done        = (r_q.st == ST_FIN);
    assign err_timeout = (r_q.st == ST_TOUT);
    assign err_range   = r_q.err_rng;

endmodule

// File: rtl/nand_pgrd_chk.sv
module nand_pgrd_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic nand_ce_n,
    input logic nand_cle,
    input logic nand_ale,
    input logic nand_we_n,
    input logic nand_re_n,
    input logic nand_io_oe,
    input logic out_valid,
    input logic out_ready,
    input logic [7:0] out_data,
    input logic out_last,
    input logic done,
    input logic err_range,
    input logic err_timeout
);
    // R1
    a_r1_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    // R1
    a_r1_we_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> !nand_ce_n);
    // R7
    a_r7_read_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> (nand_we_n && !nand_cle && !nand_ale && !nand_io_oe && !nand_ce_n));
    // R7
    a_r7_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
    // R7
    a_r7_no_strobe_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> nand_re_n);
    // R8
    a_r8_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    // R8
    a_r8_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> nand_ce_n);
    // R9
    a_r9_timeout_releases: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> (nand_ce_n && nand_re_n));
    // R10
    a_r10_refused_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        err_range |-> (nand_ce_n && $past(nand_ce_n)));
    // R12
    a_r12_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> nand_ce_n);
    // R8 R9 R10
    a_r8_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err_range, err_timeout}));
endmodule

bind nand_pgrd_seq nand_pgrd_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .nand_ce_n   (nand_ce_n),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_io_oe  (nand_io_oe),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_last    (out_last),
    .done        (done),
    .err_range   (err_range),
    .err_timeout (err_timeout)
);

// File: tb/sim_nand_pgrd_seq.sv
module sim_nand_pgrd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PULSE = 2;
    localparam int TWB   = 6;
    localparam int TW    = 10;
    localparam int LW    = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [23:0]   req_row = '0;
    logic [11:0]   req_col = '0;
    logic          req_spare = 1'b0;
    logic [LW-1:0] req_len = '0;
    logic [TW-1:0] busy_limit = '0;
    logic          nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]    nand_io_out;
    logic [7:0]    nand_io_in = '0;
    logic          nand_rb_n = 1'b1;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [7:0]    out_data;
    logic          out_last, done, err_range, err_timeout;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nand_pgrd_seq #(.PULSE_CYC(PULSE), .TWB_CYC(TWB), .TMR_W(TW), .LEN_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_row(req_row), .req_col(req_col), .req_spare(req_spare), .req_len(req_len),
        .busy_limit(busy_limit), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_io_oe(nand_io_oe), .nand_io_out(nand_io_out), .nand_io_in(nand_io_in),
        .nand_rb_n(nand_rb_n), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last), .done(done),
        .err_range(err_range), .err_timeout(err_timeout)
    );

    // Page content of the device model
    function automatic logic [7:0] dev_byte(logic [23:0] r, logic [11:0] c);
        return (r[7:0] + r[15:8] + r[23:16]) ^ c[7:0] ^ {4'h5, c[11:8]};
    endfunction

    // ---------------- device model ----------------
    logic [7:0]  cmd_log [64];
    logic [7:0]  adr_log [64];
    int          n_cmd = 0, n_adr = 0;
    int          cmd2_cnt = 0, cmd2_cyc = 0;
    logic [11:0] dev_col = '0;
    logic [23:0] dev_row = '0;
    int          re_rises = 0, rd_base = 0, first_re_cyc = 0, ce_falls = 0;
    logic        first_rb = 1'b0;
    int          busy_cfg = 0;
    int          rb_seen = 0, rb_dly = 0, rb_left = 0;

    always @(posedge nand_we_n) begin
        if (nand_cle === 1'b1) begin
            cmd_log[n_cmd % 64] = nand_io_out;
            n_cmd++;
            if (nand_io_out == 8'h30) begin
                dev_col  = {adr_log[(n_adr+60) % 64][3:0], adr_log[(n_adr+59) % 64]};
                dev_row  = {adr_log[(n_adr+63) % 64], adr_log[(n_adr+62) % 64],
                            adr_log[(n_adr+61) % 64]};
                rd_base  = re_rises;
                cmd2_cyc = cyc;
                cmd2_cnt++;
            end
        end else if (nand_ale === 1'b1) begin
            adr_log[n_adr % 64] = nand_io_out;
            n_adr++;
        end
    end

    always @(negedge nand_re_n) begin
        if (re_rises == rd_base) begin
            first_re_cyc = cyc;
            first_rb     = nand_rb_n;
        end
        nand_io_in = dev_byte(dev_row, dev_col + 12'(re_rises - rd_base));
    end
    always @(posedge nand_re_n) re_rises++;
    always @(negedge nand_ce_n) ce_falls++;

    // Busy: two clocks after the confirm opcode, low for busy_cfg clocks (<0: forever)
    always @(posedge clk) begin
        if (cmd2_cnt != rb_seen) begin
            rb_seen   = cmd2_cnt;
            rb_dly    = 2;
            rb_left   = busy_cfg;
            nand_rb_n <= 1'b1;
        end else if (rb_dly > 0) begin
            rb_dly--;
            if (rb_dly == 0 && rb_left != 0) nand_rb_n <= 1'b0;
        end else if (!nand_rb_n && rb_left > 0) begin
            rb_left--;
            if (rb_left == 0) nand_rb_n <= 1'b1;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    task automatic run_op(input logic [23:0] row, input int col, input bit spare, input int len,
                          input int busy, input int limit, input int rdy_pct);
        int  kind, col_eff, exp_n, got, bcmd, badr, ce0, re0;
        bit  fin, saw_done, saw_tout, ready_bad;
        logic [7:0] exp_adr [5];
        col_eff = spare ? 2048 + col : col;
        if (len == 0 || (spare ? col > 63 : col > 2111)) kind = 1;
        else if (busy < 0)                                 kind = 2;
        else                                               kind = 0;
        exp_n = (len < 2112 - col_eff) ? len : 2112 - col_eff;
        exp_adr[0] = col_eff[7:0];
        exp_adr[1] = {4'h0, col_eff[11:8]};
        exp_adr[2] = row[7:0];
        exp_adr[3] = row[15:8];
        exp_adr[4] = row[23:16];
        busy_cfg   = busy;
        busy_limit = TW'(limit);
        bcmd = n_cmd; badr = n_adr; ce0 = ce_falls; re0 = re_rises;
        @(negedge clk);
        chk("R12", "ready when idle", int'(req_ready), 1);
        req_row = row; req_col = 12'(col); req_spare = spare; req_len = LW'(len);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (kind == 1) begin
            chk("R10", "err_range after accept", int'(err_range), 1);
            repeat (3) @(negedge clk);
            chk("R10", "no chip select", ce_falls - ce0, 0);
            chk("R10", "no opcode sent", n_cmd - bcmd, 0);
            return;
        end
        got = 0; fin = 0; saw_done = 0; saw_tout = 0; ready_bad = 0;
        for (int it = 0; it < 20000 && !fin; it++) begin
            if (!nand_ce_n && req_ready) ready_bad = 1;
            if (done || err_timeout) begin
                fin = 1; saw_done = done; saw_tout = err_timeout;
            end else begin
                out_ready = (($urandom % 100) < rdy_pct);
                if (out_valid && out_ready) begin
                    chk("R7", "byte value", int'(out_data), int'(dev_byte(row, 12'(col_eff + got))));
                    chk("R8", "last flag", int'(out_last), int'(got == exp_n - 1));
                    got++;
                end
                @(negedge clk);
            end
        end
        out_ready = 1'b0;
        chk("R12", "ready low while selected", int'(ready_bad), 0);
        chk("R1", "opcode count", n_cmd - bcmd, 2);
        chk("R1", "first opcode", int'(cmd_log[bcmd % 64]), 8'h00);
        chk("R1", "second opcode", int'(cmd_log[(bcmd + 1) % 64]), 8'h30);
        chk("R1", "address count", n_adr - badr, 5);
        chk("R2", "column low byte", int'(adr_log[badr % 64]), int'(exp_adr[0]));
        chk("R4", "column high byte", int'(adr_log[(badr + 1) % 64]), int'(exp_adr[1]));
        for (int k = 2; k < 5; k++)
            chk("R3", "page index byte", int'(adr_log[(badr + k) % 64]), int'(exp_adr[k]));
        if (kind == 2) begin
            chk("R9", "timeout pulse", int'(saw_tout), 1);
            chk("R9", "no bytes read", re_rises - re0, 0);
            chk("R9", "chip released", int'(nand_ce_n), 1);
            chk("R9", "waited limit", int'(cyc - cmd2_cyc >= limit), 1);
        end else begin
            chk("R8", "done pulse", int'(saw_done), 1);
            chk("R8", "byte count", got, exp_n);
            chk("R8", "chip released", int'(nand_ce_n), 1);
            chk("R5", "guard before read", int'(first_re_cyc - cmd2_cyc >= TWB), 1);
            chk("R6", "ready seen at first strobe", int'(first_rb), 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual expired expected finished");
        finish_sim();
    end

    initial begin
        void'($urandom(32'd7411));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", "ce_n", int'(nand_ce_n), 1);
        chk("R11", "we_n", int'(nand_we_n), 1);
        chk("R11", "re_n", int'(nand_re_n), 1);
        chk("R11", "cle/ale", int'({nand_cle, nand_ale}), 0);
        chk("R11", "out_valid", int'(out_valid), 0);
        chk("R11", "req_ready", int'(req_ready), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 worked example: bytes B8 04 40 D6 06
        run_op(24'h06D640, 1208, 0, 8, 12, 200, 100);
        run_op(24'h000123, 10, 1, 6, 5, 200, 60);     // R4 spare offset
        run_op(24'h7A0001, 63, 1, 5, 3, 200, 100);    // R8 clipped to one byte
        run_op(24'h00ABCD, 2100, 0, 50, 7, 200, 50);  // R8 clipped to 12
        run_op(24'h123456, 2047, 0, 3, 4, 200, 100);  // crosses into spare area
        run_op(24'h0F0F0F, 0, 0, 4, 0, 200, 100);     // R5 device never busy
        run_op(24'h001000, 16, 0, 4, -1, 40, 100);    // R9 timeout
        run_op(24'h001000, 2112, 0, 4, 3, 200, 100);  // R10 column out of page
        run_op(24'h001000, 64, 1, 4, 3, 200, 100);    // R10 spare offset out of range
        run_op(24'h001000, 100, 0, 0, 3, 200, 100);   // R10 zero length
        run_op(24'h0000FF, 5, 0, 3, 40, 200, 100);    // R6 long busy

        for (int i = 0; i < 25; i++) begin
            int sel, c, l;
            bit sp;
            sel = int'($urandom % 4);
            sp  = (sel == 2);
            case (sel)
                0:       c = int'($urandom % 2048);
                1:       c = 2040 + int'($urandom % 72);
                2:       c = int'($urandom % 64);
                default: c = int'($urandom % 2200);
            endcase
            l = 1 + int'($urandom % 24);
            run_op(24'($urandom), c, sp, l, int'($urandom % 30), 200, 30 + int'($urandom % 71));
        end
        repeat (4) @(negedge clk);
        finish_sim();
    end
endmodule